// File: doc/BRIEF.md
# Compressed-Memory Translation Cache

This block sits in a memory controller that keeps main memory compressed while the rest of the system addresses it as flat, uncompressed physical memory. Every read address is translated in 1KB pages. A small set-associative cache holds recently used translation entries. Each entry records where the page's compressed data begins, which of two encodings the page uses, a compact metadata field, and a 16-bit vector that marks which 64-byte lines are entirely zero.

A hit gives a response one cycle after the request is accepted. A miss sends a single request to the in-memory mapping table and stalls the request port until the table answers. The answer is installed in an empty way, or else in the pseudo-LRU victim, and is returned as the response. Pages in the fast per-line encoding give a per-line storage offset. Pages in the dense stream encoding give the page's base address, because the whole page must be decoded. A stream-encoded response also raises a conversion request for the aligned 32KB range that holds the page. An invalidate port removes an entry when software elsewhere re-encodes its range.

Top module: `cmt_xlat_cache`

## Requirements
- R1: Once reset is released, req_ready is 1 and resp_valid, conv_valid and tbl_req_valid are all 0. No entry is valid, so the first request to any page misses.
- R2: The page number is req_addr[31:10], the set is page[2:0], the tag is page[21:3] and the line index is req_addr[9:6]. Address bits [5:0] play no part. A request hits only when its own page is cached, and two pages that share a set can be cached at the same time.
- R3: When an accepted request hits, resp_valid=1 and resp_hit=1 appear exactly one cycle later, and req_ready stays 1.
- R4: When an accepted request misses, tbl_req_valid pulses for exactly one cycle, one cycle after acceptance, with tbl_req_page equal to the page number. req_ready stays 0 until the table answers. One cycle after tbl_rsp_valid, resp_valid=1 and resp_hit=0, the response carries the table's kind and metadata, and req_ready is 1 again.
- R5: For kind 0 (fast per-line encoding) on a line whose zero bit is clear, resp_offset equals base + line*64.
- R6: For kind 1 (stream encoding), resp_offset equals base, and conv_valid pulses together with resp_valid with conv_range = address[31:15]. conv_valid stays 0 for kind 0.
- R7: When zero-vector bit [line] is set, resp_zero=1 and resp_offset=0. The kind and the conversion request are unchanged.
- R8: Filling uses the lowest-numbered empty way first. In a full set the victim is chosen by a binary-tree pseudo-LRU, where every hit or fill points the tree away from the way it touched. Example: fill pages A,B,C,D into an empty set and hit A; the next miss replaces C. Then touch B, A and D; the next miss replaces B.
- R9: inv_valid with inv_page removes that page's entry, so the next request to it misses. Invalidating a page that is not cached leaves every cached entry hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Uncompressed physical byte address |
| resp_valid | output | 1 | Response valid, one-cycle pulse |
| resp_hit | output | 1 | 1 if served from the cache, 0 if filled |
| resp_kind | output | 1 | 0 fast per-line encoding, 1 stream encoding |
| resp_zero | output | 1 | Line is all zeros, no memory access needed |
| resp_offset | output | 32 | Compressed storage address to read |
| resp_meta | output | 8 | Entry metadata |
| conv_valid | output | 1 | Request to convert a 32KB range to the fast encoding |
| conv_range | output | 17 | Number of the 32KB range to convert |
| tbl_req_valid | output | 1 | Mapping-table read request pulse |
| tbl_req_page | output | 22 | Page number to read from the table |
| tbl_rsp_valid | input | 1 | Mapping-table answer valid |
| tbl_rsp_base | input | 32 | Compressed base address of the page |
| tbl_rsp_kind | input | 1 | Encoding kind of the page |
| tbl_rsp_meta | input | 8 | Metadata of the page |
| tbl_rsp_zero | input | 16 | Zero-line vector of the page |
| inv_valid | input | 1 | Invalidate strobe |
| inv_page | input | 22 | Page number to invalidate |

## Verification
The bench sweeps all 16 lines of sixteen pages spread over every set, with two tags per set. This catches an index taken from the wrong bits, an offset scaled by the wrong line size, and a zero bit looked up at the wrong position. Each of those would show up as a wrong hit flag or a wrong address on one line. Mixed encodings check that the stream case neither adds the line offset nor drops its 32KB conversion request, and that the fast case never raises one. A scripted fill-and-touch order in one set exposes a replacement tree that updates the wrong node, because the wrong page would then miss later. Invalidates of cached and uncached pages catch a compare that clears the wrong way or the whole set.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // controller phases around a single outstanding table read
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_WAIT = 2'd2
  } cmt_state_e;

  // encoding kind carried by each entry
  localparam logic KIND_FAST   = 1'b0;
  localparam logic KIND_STREAM = 1'b1;

endpackage

// File: rtl/cmt_plru.sv
module cmt_plru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int NODES  = WAYS - 1,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);

  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d;

  // walk from the root following each node bit (0 = left half)
  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] t);
    logic [NODE_W-1:0] node;
    logic [WAY_W-1:0]  w;
    node = '0;
    w    = '0;
    for (int l = 0; l < WAY_W; l++) begin
      w    = (w << 1) | WAY_W'(t[node]);
      node = (node << 1) + NODE_W'(1) + NODE_W'(t[node]);
    end
    return w;
  endfunction

  // point every node on the path away from the touched way
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODE_W-1:0] node;
    logic [WAY_W-1:0]  ww;
    logic [NODES-1:0]  r;
    logic              dir;
    node = '0;
    ww   = w;
    r    = t;
    for (int l = 0; l < WAY_W; l++) begin
      dir     = ww[WAY_W-1];
      ww      = ww << 1;
      r[node] = ~dir;
      node    = (node << 1) + NODE_W'(1) + NODE_W'(dir);
    end
    return r;
  endfunction

  assign tree_d = touch(tree_q[upd_set], upd_way);
  assign victim = pick(tree_q[rd_set]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[upd_set] <= tree_d;
    end
  end

endmodule

// File: rtl/cmt_tag_ram.sv
module cmt_tag_ram #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 19,
  parameter int BASE_W = 32,
  parameter int META_W = 8,
  parameter int ZV_W   = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [BASE_W-1:0] lk_base,
  output logic              lk_kind,
  output logic [META_W-1:0] lk_meta,
  output logic [ZV_W-1:0]   lk_zero,
  output logic              lk_has_free,
  output logic [WAY_W-1:0]  lk_free_way,
  // install
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              wr_kind,
  input  logic [META_W-1:0] wr_meta,
  input  logic [ZV_W-1:0]   wr_zero,
  // drop
  input  logic              inv_en,
  input  logic [SET_W-1:0]  inv_set,
  input  logic [TAG_W-1:0]  inv_tag
);

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   valid_d [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [BASE_W-1:0] base_q  [SETS][WAYS];
  logic              kind_q  [SETS][WAYS];
  logic [META_W-1:0] meta_q  [SETS][WAYS];
  logic [ZV_W-1:0]   zero_q  [SETS][WAYS];

  logic [WAYS-1:0] hit_vec;
  logic [WAYS-1:0] free_vec;
  logic [WAYS-1:0] inv_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]  = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign free_vec[w] = !valid_q[lk_set][w];
    assign inv_vec[w]  = valid_q[inv_set][w] && (tag_q[inv_set][w] == inv_tag);
  end

  // lowest index wins for both encoders
  always_comb begin
    lk_way      = '0;
    lk_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  lk_way      = WAY_W'(w);
      if (free_vec[w]) lk_free_way = WAY_W'(w);
    end
  end

  assign lk_hit      = |hit_vec;
  assign lk_has_free = |free_vec;
  assign lk_base     = base_q[lk_set][lk_way];
  assign lk_kind     = kind_q[lk_set][lk_way];
  assign lk_meta     = meta_q[lk_set][lk_way];
  assign lk_zero     = zero_q[lk_set][lk_way];

  // invalidate first, then an install in the same cycle decides its own bit
  always_comb begin
    for (int s = 0; s < SETS; s++) valid_d[s] = valid_q[s];
    if (inv_en) valid_d[inv_set] = valid_q[inv_set] & ~inv_vec;
    if (wr_en)  valid_d[wr_set][wr_way] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  // payload storage carries no reset; valid bits guard it
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q [wr_set][wr_way] <= wr_tag;
      base_q[wr_set][wr_way] <= wr_base;
      kind_q[wr_set][wr_way] <= wr_kind;
      meta_q[wr_set][wr_way] <= wr_meta;
      zero_q[wr_set][wr_way] <= wr_zero;
    end
  end

endmodule

// File: rtl/cmt_route.sv
module cmt_route
  import cmt_pkg::*;
#(
  parameter int BASE_W  = 32,
  parameter int LIDX_W  = 4,
  parameter int LINE_SH = 6,
  localparam int LINES  = 1 << LIDX_W
) (
  input  logic              kind,
  input  logic [BASE_W-1:0] base,
  input  logic [LINES-1:0]  zero_vec,
  input  logic [LIDX_W-1:0] line,
  output logic [BASE_W-1:0] offset,
  output logic              is_zero,
  output logic              want_conv
);

  logic [BASE_W-1:0] line_bytes;

  assign line_bytes = BASE_W'(line) << LINE_SH;
  assign is_zero    = zero_vec[line];
  assign want_conv  = (kind == KIND_STREAM);

  always_comb begin
    if (is_zero)                  offset = '0;
    else if (kind == KIND_STREAM) offset = base;
    else                          offset = base + line_bytes;
  end

endmodule

// File: rtl/cmt_xlat_cache.sv
module cmt_xlat_cache
  import cmt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BASE_W      = 32,
  parameter int META_W      = 8,
  parameter int SETS        = 8,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 64,
  parameter int PAGE_BYTES  = 1024,
  parameter int RANGE_BYTES = 32768,
  localparam int LINE_SH  = $clog2(LINE_BYTES),
  localparam int PAGE_SH  = $clog2(PAGE_BYTES),
  localparam int RANGE_SH = $clog2(RANGE_BYTES),
  localparam int LINES    = PAGE_BYTES / LINE_BYTES,
  localparam int LIDX_W   = PAGE_SH - LINE_SH,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int PAGE_W   = ADDR_W - PAGE_SH,
  localparam int TAG_W    = PAGE_W - SET_W,
  localparam int RANGE_W  = ADDR_W - RANGE_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_kind,
  output logic               resp_zero,
  output logic [BASE_W-1:0]  resp_offset,
  output logic [META_W-1:0]  resp_meta,
  output logic               conv_valid,
  output logic [RANGE_W-1:0] conv_range,
  output logic               tbl_req_valid,
  output logic [PAGE_W-1:0]  tbl_req_page,
  input  logic               tbl_rsp_valid,
  input  logic [BASE_W-1:0]  tbl_rsp_base,
  input  logic               tbl_rsp_kind,
  input  logic [META_W-1:0]  tbl_rsp_meta,
  input  logic [LINES-1:0]   tbl_rsp_zero,
  input  logic               inv_valid,
  input  logic [PAGE_W-1:0]  inv_page
);

  // ---------------- reset release ----------------
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // ---------------- control state ----------------
  cmt_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pend_q;
  logic              pend_en;
  logic              in_wait;
  logic              accept;
  logic              fill;
  logic              fill_keep;

  // ---------------- address slicing ----------------
  logic [ADDR_W-1:0] cur_addr;
  logic [PAGE_W-1:0] cur_page;
  logic [PAGE_W-1:0] pend_page;
  logic [SET_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [LIDX_W-1:0] cur_line;

  assign in_wait   = (state_q == ST_WAIT);
  assign cur_addr  = in_wait ? pend_q : req_addr;
  assign cur_page  = cur_addr[ADDR_W-1:PAGE_SH];
  assign cur_set   = cur_page[SET_W-1:0];
  assign cur_tag   = cur_page[PAGE_W-1:SET_W];
  assign cur_line  = cur_addr[PAGE_SH-1:LINE_SH];
  assign pend_page = pend_q[ADDR_W-1:PAGE_SH];

  // ---------------- lookup storage ----------------
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic [BASE_W-1:0] lk_base;
  logic              lk_kind;
  logic [META_W-1:0] lk_meta;
  logic [LINES-1:0]  lk_zero;
  logic              lk_has_free;
  logic [WAY_W-1:0]  lk_free_way;
  logic [WAY_W-1:0]  plru_victim;
  logic [WAY_W-1:0]  way_sel;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fill      = in_wait && tbl_rsp_valid;
  assign fill_keep = !(inv_valid && (inv_page == pend_page));
  assign way_sel   = lk_has_free ? lk_free_way : plru_victim;

  cmt_tag_ram #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .BASE_W(BASE_W),
    .META_W(META_W),
    .ZV_W  (LINES)
  ) u_tags (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .lk_set     (cur_set),
    .lk_tag     (cur_tag),
    .lk_hit     (lk_hit),
    .lk_way     (lk_way),
    .lk_base    (lk_base),
    .lk_kind    (lk_kind),
    .lk_meta    (lk_meta),
    .lk_zero    (lk_zero),
    .lk_has_free(lk_has_free),
    .lk_free_way(lk_free_way),
    .wr_en      (fill),
    .wr_valid   (fill_keep),
    .wr_set     (cur_set),
    .wr_way     (way_sel),
    .wr_tag     (cur_tag),
    .wr_base    (tbl_rsp_base),
    .wr_kind    (tbl_rsp_kind),
    .wr_meta    (tbl_rsp_meta),
    .wr_zero    (tbl_rsp_zero),
    .inv_en     (inv_valid),
    .inv_set    (inv_page[SET_W-1:0]),
    .inv_tag    (inv_page[PAGE_W-1:SET_W])
  );

  logic             plru_upd;
  logic [WAY_W-1:0] plru_way;

  assign plru_upd = (accept && lk_hit) || (fill && fill_keep);
  assign plru_way = in_wait ? way_sel : lk_way;

  cmt_plru #(
    .SETS(SETS),
    .WAYS(WAYS)
  ) u_plru (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .rd_set (cur_set),
    .victim (plru_victim),
    .upd_en (plru_upd),
    .upd_set(cur_set),
    .upd_way(plru_way)
  );

  // ---------------- response routing ----------------
  logic              src_kind;
  logic [BASE_W-1:0] src_base;
  logic [META_W-1:0] src_meta;
  logic [LINES-1:0]  src_zero;
  logic [BASE_W-1:0] rt_offset;
  logic              rt_zero;
  logic              rt_conv;
  logic              resp_load;

  assign src_kind  = in_wait ? tbl_rsp_kind : lk_kind;
  assign src_base  = in_wait ? tbl_rsp_base : lk_base;
  assign src_meta  = in_wait ? tbl_rsp_meta : lk_meta;
  assign src_zero  = in_wait ? tbl_rsp_zero : lk_zero;
  assign resp_load = (accept && lk_hit) || fill;

  cmt_route #(
    .BASE_W (BASE_W),
    .LIDX_W (LIDX_W),
    .LINE_SH(LINE_SH)
  ) u_route (
    .kind     (src_kind),
    .base     (src_base),
    .zero_vec (src_zero),
    .line     (cur_line),
    .offset   (rt_offset),
    .is_zero  (rt_zero),
    .want_conv(rt_conv)
  );

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    pend_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept && !lk_hit) begin
        state_d = ST_ASK;
        pend_en = 1'b1;
      end
      ST_ASK:  state_d = ST_WAIT;
      ST_WAIT: if (tbl_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= req_addr;
    end
  end

  // ---------------- response registers ----------------
  logic               resp_valid_q;
  logic               resp_hit_q;
  logic               resp_kind_q;
  logic               resp_zero_q;
  logic [BASE_W-1:0]  resp_offset_q;
  logic [META_W-1:0]  resp_meta_q;
  logic               conv_valid_q;
  logic [RANGE_W-1:0] conv_range_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      resp_valid_q  <= 1'b0;
      conv_valid_q  <= 1'b0;
      resp_hit_q    <= 1'b0;
      resp_kind_q   <= KIND_FAST;
      resp_zero_q   <= 1'b0;
      resp_offset_q <= '0;
      resp_meta_q   <= '0;
      conv_range_q  <= '0;
    end else begin
      resp_valid_q <= resp_load;
      conv_valid_q <= resp_load && rt_conv;
      if (resp_load) begin
        resp_hit_q    <= !in_wait;
        resp_kind_q   <= src_kind;
        resp_zero_q   <= rt_zero;
        resp_offset_q <= rt_offset;
        resp_meta_q   <= src_meta;
        conv_range_q  <= cur_addr[ADDR_W-1:RANGE_SH];
      end
    end
  end

  assign resp_valid    = resp_valid_q;
  assign resp_hit      = resp_hit_q;
  assign resp_kind     = resp_kind_q;
  assign resp_zero     = resp_zero_q;
  assign resp_offset   = resp_offset_q;
  assign resp_meta     = resp_meta_q;
  assign conv_valid    = conv_valid_q;
  assign conv_range    = conv_range_q;
  assign tbl_req_valid = (state_q == ST_ASK);
  assign tbl_req_page  = pend_page;

endmodule

// File: rtl/cmt_xlat_cache_chk.sv
module cmt_xlat_cache_chk #(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_kind,
  input logic              resp_zero,
  input logic [BASE_W-1:0] resp_offset,
  input logic              conv_valid,
  input logic              tbl_req_valid,
  input logic              tbl_rsp_valid
);

  AST_TBL_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req_valid |=> !tbl_req_valid); // R4

  AST_STALL_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req_valid |-> !req_ready); // R4

  AST_FILL_RESP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(tbl_rsp_valid)); // R4

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || tbl_req_valid)); // R3

  AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(tbl_rsp_valid))); // R3

  AST_CONV_ONLY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (resp_valid && resp_kind)); // R6

  AST_ZERO_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_zero) |-> (resp_offset == '0)); // R7

endmodule

bind cmt_xlat_cache cmt_xlat_cache_chk #(
  .BASE_W(BASE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .resp_valid   (resp_valid),
  .resp_hit     (resp_hit),
  .resp_kind    (resp_kind),
  .resp_zero    (resp_zero),
  .resp_offset  (resp_offset),
  .conv_valid   (conv_valid),
  .tbl_req_valid(tbl_req_valid),
  .tbl_rsp_valid(tbl_rsp_valid)
);

// File: tb/cmt_xlat_cache_bench.sv
module cmt_xlat_cache_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        resp_valid;
  logic        resp_hit;
  logic        resp_kind;
  logic        resp_zero;
  logic [31:0] resp_offset;
  logic [7:0]  resp_meta;
  logic        conv_valid;
  logic [16:0] conv_range;
  logic        tbl_req_valid;
  logic [21:0] tbl_req_page;
  logic        tbl_rsp_valid;
  logic [31:0] tbl_rsp_base;
  logic        tbl_rsp_kind;
  logic [7:0]  tbl_rsp_meta;
  logic [15:0] tbl_rsp_zero;
  logic        inv_valid;
  logic [21:0] inv_page;

  int checks;
  int failures;

  cmt_xlat_cache u_cmt_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_kind(resp_kind),
    .resp_zero(resp_zero), .resp_offset(resp_offset), .resp_meta(resp_meta),
    .conv_valid(conv_valid), .conv_range(conv_range),
    .tbl_req_valid(tbl_req_valid), .tbl_req_page(tbl_req_page),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_base(tbl_rsp_base),
    .tbl_rsp_kind(tbl_rsp_kind), .tbl_rsp_meta(tbl_rsp_meta),
    .tbl_rsp_zero(tbl_rsp_zero),
    .inv_valid(inv_valid), .inv_page(inv_page)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // mapping-table contents, computed from the page number
  function automatic logic [31:0] f_base(input logic [21:0] p);
    return 32'h4000_0000 + 32'(p) * 32'h340;
  endfunction
  function automatic logic f_kind(input logic [21:0] p);
    return p[1];
  endfunction
  function automatic logic [7:0] f_meta(input logic [21:0] p);
    return 8'(32'(p) * 7 + 3);
  endfunction
  function automatic logic [15:0] f_zero(input logic [21:0] p);
    return (16'h1 << ((32'(p) * 5) % 16)) | (p[2] ? 16'h0300 : 16'h0000);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    req_addr      = '0;
    tbl_rsp_valid = 1'b0;
    tbl_rsp_base  = '0;
    tbl_rsp_kind  = 1'b0;
    tbl_rsp_meta  = '0;
    tbl_rsp_zero  = '0;
    inv_valid     = 1'b0;
    inv_page      = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one translation; table answers after lat idle cycles on a miss
  task automatic do_req(input logic [31:0] addr, input bit exp_hit, input int lat);
    logic [21:0] pg;
    int          ln;
    logic [31:0] exp_off;
    logic        z;
    pg = addr[31:10];
    ln = int'(addr[9:6]);
    @(negedge clk);
    chk("R3 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk("R3 hit response valid", 64'(resp_valid), 64'd1);
      chk("R2 hit flag", 64'(resp_hit), 64'd1);
      chk("R3 ready after hit", 64'(req_ready), 64'd1);
    end else begin
      chk("R4 no early response", 64'(resp_valid), 64'd0);
      chk("R2 miss table request", 64'(tbl_req_valid), 64'd1);
      chk("R4 table page", 64'(tbl_req_page), 64'(pg));
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk("R4 stalled", 64'(req_ready), 64'd0);
        chk("R4 request pulse ends", 64'(tbl_req_valid), 64'd0);
      end
      tbl_rsp_valid = 1'b1;
      tbl_rsp_base  = f_base(pg);
      tbl_rsp_kind  = f_kind(pg);
      tbl_rsp_meta  = f_meta(pg);
      tbl_rsp_zero  = f_zero(pg);
      @(negedge clk);
      tbl_rsp_valid = 1'b0;
      chk("R4 fill response valid", 64'(resp_valid), 64'd1);
      chk("R4 fill flag", 64'(resp_hit), 64'd0);
      chk("R4 ready after fill", 64'(req_ready), 64'd1);
    end
    z = f_zero(pg)[ln];
    if (z)                exp_off = 32'h0;
    else if (f_kind(pg))  exp_off = f_base(pg);
    else                  exp_off = f_base(pg) + 32'(ln) * 32'd64;
    chk("R4 kind", 64'(resp_kind), 64'(f_kind(pg)));
    chk("R4 meta", 64'(resp_meta), 64'(f_meta(pg)));
    chk("R7 zero flag", 64'(resp_zero), 64'(z));
    if (z)               chk("R7 zero offset", 64'(resp_offset), 64'(exp_off));
    else if (f_kind(pg)) chk("R6 stream offset", 64'(resp_offset), 64'(exp_off));
    else                 chk("R5 fast offset", 64'(resp_offset), 64'(exp_off));
    chk("R6 conversion strobe", 64'(conv_valid), 64'(f_kind(pg)));
    if (f_kind(pg)) chk("R6 conversion range", 64'(conv_range), 64'(addr[31:15]));
  endtask

  task automatic do_inv(input logic [21:0] p);
    @(negedge clk);
    inv_valid = 1'b1;
    inv_page  = p;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  function automatic logic [21:0] sweep_page(input int i);
    return 22'((i % 8) + (i / 8) * 296);
  endfunction

  function automatic logic [31:0] mk_addr(input logic [21:0] p, input int ln);
    return {p, 4'(ln), 6'((ln * 5) & 63)};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    do_reset();

    // R1: reset state
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 resp idle", 64'(resp_valid), 64'd0);
    chk("R1 conv idle", 64'(conv_valid), 64'd0);
    chk("R1 table idle", 64'(tbl_req_valid), 64'd0);

    // R2 R5 R6 R7: every line of sixteen pages, two tags per set
    for (int i = 0; i < 16; i++) begin
      for (int ln = 0; ln < 16; ln++) begin
        do_req(mk_addr(sweep_page(i), ln), ln != 0, 1 + (i % 3));
      end
    end
    // R2: both tags of every set still resident
    for (int i = 0; i < 16; i++) do_req(mk_addr(sweep_page(i), 7), 1'b1, 1);

    // R8: replacement order in set 3
    do_reset();
    for (int k = 1; k <= 4; k++) do_req(mk_addr(22'(3 + 8 * k), 2), 1'b0, 2); // A B C D
    do_req(mk_addr(22'(3 + 8 * 1), 4), 1'b1, 1);  // touch A
    do_req(mk_addr(22'(3 + 8 * 5), 4), 1'b0, 1);  // E replaces C (R8)
    do_req(mk_addr(22'(3 + 8 * 2), 5), 1'b1, 1);  // B
    do_req(mk_addr(22'(3 + 8 * 1), 5), 1'b1, 1);  // A
    do_req(mk_addr(22'(3 + 8 * 4), 5), 1'b1, 1);  // D
    do_req(mk_addr(22'(3 + 8 * 3), 5), 1'b0, 1);  // C misses, replaces B (R8)
    do_req(mk_addr(22'(3 + 8 * 5), 6), 1'b1, 1);  // E kept
    do_req(mk_addr(22'(3 + 8 * 2), 6), 1'b0, 1);  // B was the victim (R8)

    // R9: invalidate
    do_reset();
    do_req(mk_addr(22'h00_1234, 1), 1'b0, 1);
    do_req(mk_addr(22'h00_0ab9, 1), 1'b0, 1);
    do_inv(22'h00_1234);
    do_req(mk_addr(22'h00_0ab9, 2), 1'b1, 1);  // R9 other entry untouched
    do_req(mk_addr(22'h00_1234, 2), 1'b0, 1);  // R9 dropped entry misses
    do_inv(22'h00_1a34);                         // R9 same set, not cached
    do_req(mk_addr(22'h00_1234, 3), 1'b1, 1);
    do_req(mk_addr(22'h00_0ab9, 3), 1'b1, 1);

    // R4: long table latency
    do_req(mk_addr(22'h3f_fff2, 9), 1'b0, 12);
    do_req(mk_addr(22'h3f_fff2, 10), 1'b1, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule